// File: doc/BRIEF.md
# Operand Address Generator

This unit produces data-memory operand addresses for a signal-processing core. It holds eight auxiliary address registers, a pointer that picks the active one, and a page register. Each cycle the core's decoder hands it one decoded command. Some commands only update registers. Others also produce one address, either direct (page joined with a short offset from the instruction) or indirect (the active auxiliary register, optionally modified after use).

Indirect updates are more than a simple step up or down. A circular update keeps a pointer inside a buffer given by a base and a length, so stepping past either end wraps around. A bit-reversed update adds a step with the carry running from the high bit toward the low bit over a chosen number of low bits, which walks FFT operands in shuffled order. An indirect command puts the register's value before the update on the address bus. The updated value is in effect from the next cycle.

Commands arrive as a plain strobe (`cmd_valid`) with no back-pressure, because every command completes in one cycle. The address leaves as a qualified word (`addr_valid`, `addr_out`) that the memory side must take in the same cycle. A core that needs to stall simply withholds `cmd_valid`. The circular and bit-reversal settings are static control pins.

Top module: `dag_addr_unit`

## Requirements
- R1: After reset, all eight auxiliary registers, the pointer and the page register are zero, and `addr_valid` is low while no command is presented.
- R2: Command 6 loads the page register from `cmd_imm[8:0]`. Command 7 outputs `{page, cmd_imm[6:0]}` with `addr_valid` high.
- R3: Command 8 outputs the active register unchanged. Command 9 outputs it, then adds 1. Command 10 outputs it, then subtracts 1. Arithmetic is modulo 2^16, and the new value shows from the next cycle.
- R4: Command 1 loads the active register with `cmd_imm[7:0]` zero-extended. Command 2 loads all 16 bits of `cmd_imm`.
- R5: Command 3 adds and command 4 subtracts the unsigned `cmd_imm[7:0]` to or from the active register, modulo 2^16, without producing an address.
- R6: Command 5 loads the pointer from `cmd_imm[2:0]`. Later commands act on the newly chosen register, and every other register keeps its value.
- R7: Command 11 outputs the active register, then adds step `cmd_imm[7:0]`. If the sum is at or beyond `circ_base + circ_len`, `circ_len` is subtracted from it.
- R8: Command 12 outputs the active register, then subtracts the step. If the result would fall below `circ_base`, `circ_len` is added to it.
- R9: Command 13 outputs the active register, then adds `rev_step` to its low N bits (N = `rev_span` + 1, from 1 to 16) with the carry running from bit N-1 toward bit 0. The carry out is discarded, and bits above N are kept.
- R10: While `cmd_valid` is low, no register changes and `addr_valid` stays low.
- R11: `addr_valid` is high only for commands 7 to 13 with `cmd_valid` high. Otherwise `addr_out` reads zero. Command 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Decoded command code (see requirements) |
| cmd_imm | input | 16 | Constant, offset, page or pointer value |
| circ_base | input | 16 | Circular buffer start address |
| circ_len | input | 16 | Circular buffer length in words |
| rev_span | input | 4 | Bit-reversal field width minus one |
| rev_step | input | 16 | Step added in bit-reversed order |
| addr_valid | output | 1 | `addr_out` carries an operand address |
| addr_out | output | 16 | Data-memory address |

## Verification
The bench steps a circular pointer forward across the end of its buffer and backward across the base. A unit that compared with the wrong bound would leave the buffer or wrap one word early. It runs a bit-reversed walk at a field width of 4 and at both extremes, 1 and 16. A carry sent the wrong way, a mask that is off by one bit, or disturbed upper bits would show up as a wrong address. Post-decrement from zero and post-increment from all ones test the modulo wrap. A pointer change followed by a read of an earlier register catches writes made to the wrong register. An idle cycle with an increment command on the bus, and a mid-run reset, show whether state leaks while the unit should be inert.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LD8    = 4'd1,
    OP_LD16   = 4'd2,
    OP_ADDK   = 4'd3,
    OP_SUBK   = 4'd4,
    OP_LDPTR  = 4'd5,
    OP_LDPAGE = 4'd6,
    OP_DIRECT = 4'd7,
    OP_IND    = 4'd8,
    OP_INC    = 4'd9,
    OP_DEC    = 4'd10,
    OP_CINC   = 4'd11,
    OP_CDEC   = 4'd12,
    OP_REV    = 4'd13
  } dag_op_e;
endpackage

// File: rtl/dag_circ_step.sv
module dag_circ_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic          dec,
  output logic [AW-1:0] nxt
);
  logic [AW:0] sum_w, lim_w, floor_w;
  logic [AW:0] inc_res;
  logic [AW-1:0] dec_res;

  always_comb begin
    sum_w   = {1'b0, cur} + {1'b0, step};
    lim_w   = {1'b0, base} + {1'b0, len};
    floor_w = {1'b0, base} + {1'b0, step};
    inc_res = (sum_w >= lim_w) ? (sum_w - {1'b0, len}) : sum_w;
    dec_res = ({1'b0, cur} < floor_w) ? (cur - step + len) : (cur - step);
    nxt     = dec ? dec_res : inc_res[AW-1:0];
  end
endmodule

// File: rtl/dag_rev_step.sv
module dag_rev_step #(
  parameter int AW     = 16,
  parameter int SPAN_W = 4
) (
  input  logic [AW-1:0]     cur,
  input  logic [AW-1:0]     step,
  input  logic [SPAN_W-1:0] span,
  output logic [AW-1:0]     nxt
);
  logic [AW:0]   mask_w;
  logic [AW-1:0] mask, a_top, s_top, a_rev, s_rev, sum_rev, sum_top;
  int unsigned   width, shamt;

  always_comb begin
    width  = int'(span) + 1;
    shamt  = AW - width;
    mask_w = ({{AW{1'b0}}, 1'b1} << width) - 1'b1;
    mask   = mask_w[AW-1:0];
    a_top  = cur << shamt;
    s_top  = step << shamt;
    for (int i = 0; i < AW; i++) begin
      a_rev[i] = a_top[AW-1-i];
      s_rev[i] = s_top[AW-1-i];
    end
    sum_rev = (a_rev + s_rev) & mask;
    for (int i = 0; i < AW; i++) sum_top[i] = sum_rev[AW-1-i];
    nxt = (cur & ~mask) | (sum_top >> shamt);
  end
endmodule

// File: rtl/dag_ar_file.sv
module dag_ar_file #(
  parameter int AW     = 16,
  parameter int NUM_AR = 8,
  parameter int PTR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] idx,
  input  logic [AW-1:0]    wr_data,
  output logic [AW-1:0]    rd_data
);
  logic [AW-1:0] regs [NUM_AR];

  for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
    always_ff @(posedge clk) begin
      if (!rst_n)                                   regs[g] <= '0;
      else if (wr_en && (idx == PTR_W'(g)))         regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[idx];
endmodule

// File: rtl/dag_addr_unit.sv
module dag_addr_unit #(
  parameter int PAGE_W  = 9,
  parameter int OFS_W   = 7,
  parameter int NUM_AR  = 8,
  parameter int SHORT_W = 8,
  parameter int AW      = PAGE_W + OFS_W,
  parameter int PTR_W   = $clog2(NUM_AR),
  parameter int SPAN_W  = $clog2(AW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [AW-1:0]     cmd_imm,
  input  logic [AW-1:0]     circ_base,
  input  logic [AW-1:0]     circ_len,
  input  logic [SPAN_W-1:0] rev_span,
  input  logic [AW-1:0]     rev_step,
  output logic              addr_valid,
  output logic [AW-1:0]     addr_out
);
  import dag_pkg::*;

  localparam int ZPAD = AW - SHORT_W;

  dag_op_e           op;
  logic [PTR_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     sel_val, ar_next, circ_nxt, rev_nxt, short_k;
  logic              ar_we;

  assign op      = dag_op_e'(cmd_op);
  assign short_k = {{ZPAD{1'b0}}, cmd_imm[SHORT_W-1:0]};

  dag_ar_file #(.AW(AW), .NUM_AR(NUM_AR), .PTR_W(PTR_W)) u_ar (
    .clk(clk), .rst_n(rst_n), .wr_en(ar_we), .idx(ptr_q),
    .wr_data(ar_next), .rd_data(sel_val)
  );

  dag_circ_step #(.AW(AW)) u_circ (
    .cur(sel_val), .step(short_k), .base(circ_base), .len(circ_len),
    .dec(op == OP_CDEC), .nxt(circ_nxt)
  );

  dag_rev_step #(.AW(AW), .SPAN_W(SPAN_W)) u_rev (
    .cur(sel_val), .step(rev_step), .span(rev_span), .nxt(rev_nxt)
  );

  always_comb begin
    ar_we   = cmd_valid;
    ar_next = sel_val;
    unique case (op)
      OP_LD8:           ar_next = short_k;
      OP_LD16:          ar_next = cmd_imm;
      OP_ADDK:          ar_next = sel_val + short_k;
      OP_SUBK:          ar_next = sel_val - short_k;
      OP_INC:           ar_next = sel_val + 1'b1;
      OP_DEC:           ar_next = sel_val - 1'b1;
      OP_CINC, OP_CDEC: ar_next = circ_nxt;
      OP_REV:           ar_next = rev_nxt;
      default:          ar_we   = 1'b0;
    endcase
  end

  always_comb begin
    addr_valid = 1'b0;
    addr_out   = '0;
    if (cmd_valid) begin
      unique case (op)
        OP_DIRECT: begin
          addr_valid = 1'b1;
          addr_out   = {page_q, cmd_imm[OFS_W-1:0]};
        end
        OP_IND, OP_INC, OP_DEC, OP_CINC, OP_CDEC, OP_REV: begin
          addr_valid = 1'b1;
          addr_out   = sel_val;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (cmd_valid) begin
      if (op == OP_LDPTR)  ptr_q  <= cmd_imm[PTR_W-1:0];
      if (op == OP_LDPAGE) page_q <= cmd_imm[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/dag_addr_unit_chk.sv
module dag_addr_unit_chk #(
  parameter int AW     = 16,
  parameter int PTR_W  = 3,
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [AW-1:0]     cmd_imm,
  input logic              addr_valid,
  input logic [AW-1:0]     addr_out,
  input logic [AW-1:0]     sel_val,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [PAGE_W-1:0] page_q
);
  import dag_pkg::*;

  p_direct_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_DIRECT) |-> (addr_valid && addr_out[OFS_W-1:0] == cmd_imm[OFS_W-1:0]));

  p_post_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INC) |=> (sel_val == $past(sel_val) + 1'b1));

  p_ld16_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LD16) |=> (sel_val == $past(cmd_imm)));

  p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LDPTR) |=> (ptr_q == $past(cmd_imm[PTR_W-1:0])));

  p_idle_no_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !addr_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(sel_val) && $stable(ptr_q) && $stable(page_q)));

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (addr_out == '0));
endmodule

bind dag_addr_unit dag_addr_unit_chk #(
  .AW(AW), .PTR_W(PTR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_imm(cmd_imm), .addr_valid(addr_valid), .addr_out(addr_out),
  .sel_val(sel_val), .ptr_q(ptr_q), .page_q(page_q)
);

// File: tb/dag_addr_unit_tb.sv
module dag_addr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_imm = '0;
  logic [15:0] circ_base = 16'h0100;
  logic [15:0] circ_len = 16'h0010;
  logic [3:0]  rev_span = 4'd3;
  logic [15:0] rev_step = 16'h0008;
  logic        addr_valid;
  logic [15:0] addr_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dag_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .circ_base(circ_base), .circ_len(circ_len),
    .rev_span(rev_span), .rev_step(rev_step),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  // {req, op, imm, expected valid, expected address}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd2,  4'd6,  16'h01A5, 1'b0, 16'h0000}, // R2 load page
    {4'd2,  4'd7,  16'h0053, 1'b1, 16'hD2D3}, // R2 direct
    {4'd4,  4'd2,  16'h1234, 1'b0, 16'h0000}, // R4 long load
    {4'd3,  4'd9,  16'h0000, 1'b1, 16'h1234}, // R3 post-inc
    {4'd3,  4'd10, 16'h0000, 1'b1, 16'h1235}, // R3 post-dec
    {4'd3,  4'd8,  16'h0000, 1'b1, 16'h1234}, // R3 plain
    {4'd5,  4'd3,  16'h00FF, 1'b0, 16'h0000}, // R5 add
    {4'd5,  4'd8,  16'h0000, 1'b1, 16'h1333},
    {4'd5,  4'd4,  16'h0040, 1'b0, 16'h0000}, // R5 sub
    {4'd5,  4'd8,  16'h0000, 1'b1, 16'h12F3},
    {4'd4,  4'd1,  16'hABCD, 1'b0, 16'h0000}, // R4 short load
    {4'd4,  4'd8,  16'h0000, 1'b1, 16'h00CD},
    {4'd6,  4'd5,  16'h0005, 1'b0, 16'h0000}, // R6 pointer
    {4'd6,  4'd8,  16'h0000, 1'b1, 16'h0000},
    {4'd7,  4'd2,  16'h010E, 1'b0, 16'h0000},
    {4'd7,  4'd11, 16'h0001, 1'b1, 16'h010E}, // R7 no wrap
    {4'd7,  4'd11, 16'h0003, 1'b1, 16'h010F}, // R7 wraps to 0x102
    {4'd8,  4'd12, 16'h0004, 1'b1, 16'h0102}, // R8 wraps to 0x10E
    {4'd8,  4'd8,  16'h0000, 1'b1, 16'h010E},
    {4'd6,  4'd5,  16'h0000, 1'b0, 16'h0000},
    {4'd6,  4'd8,  16'h0000, 1'b1, 16'h00CD}, // R6 AR0 kept
    {4'd6,  4'd5,  16'h0002, 1'b0, 16'h0000},
    {4'd9,  4'd2,  16'hF000, 1'b0, 16'h0000},
    {4'd9,  4'd13, 16'h0000, 1'b1, 16'hF000}, // R9 N=4
    {4'd9,  4'd13, 16'h0000, 1'b1, 16'hF008},
    {4'd9,  4'd13, 16'h0000, 1'b1, 16'hF004},
    {4'd9,  4'd13, 16'h0000, 1'b1, 16'hF00C},
    {4'd9,  4'd8,  16'h0000, 1'b1, 16'hF002},
    {4'd6,  4'd5,  16'h0003, 1'b0, 16'h0000},
    {4'd3,  4'd10, 16'h0000, 1'b1, 16'h0000}, // R3 dec from zero
    {4'd3,  4'd9,  16'h0000, 1'b1, 16'hFFFF}, // R3 inc from ones
    {4'd3,  4'd8,  16'h0000, 1'b1, 16'h0000},
    {4'd11, 4'd0,  16'h0000, 1'b0, 16'h0000}, // R11 nop
    {4'd11, 4'd5,  16'h0003, 1'b0, 16'h0000}  // R11 no address
  };

  task automatic step(input logic v, input logic [3:0] op, input logic [15:0] imm,
                      input logic ev, input logic [15:0] ea, input string tag);
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    cmd_imm   = imm;
    #1;
    checks++;
    if (addr_valid !== ev || addr_out !== ea) begin
      fails++;
      $display("FAIL %s: valid/addr = %0b/%h, expected %0b/%h", tag, addr_valid, addr_out, ev, ea);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'd0, 16'h0, 1'b0, 16'h0000, "R1 reset idle");
    step(1'b1, 4'd8, 16'h0, 1'b1, 16'h0000, "R1 reset AR0");
    step(1'b1, 4'd7, 16'h007F, 1'b1, 16'h007F, "R1 reset page");

    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = $sformatf("R%0d vector %0d", VEC[i][40:37], i);
      step(1'b1, VEC[i][36:33], VEC[i][32:17], VEC[i][16], VEC[i][15:0], t);
    end

    // R9 widest field: AR3 is zero here
    rev_span = 4'd15; rev_step = 16'h8000;
    step(1'b1, 4'd13, 16'h0, 1'b1, 16'h0000, "R9 N=16 first");
    step(1'b1, 4'd13, 16'h0, 1'b1, 16'h8000, "R9 N=16 second");
    step(1'b1, 4'd8,  16'h0, 1'b1, 16'h4000, "R9 N=16 result");
    // R9 narrowest field
    step(1'b1, 4'd2,  16'hABCE, 1'b0, 16'h0000, "R9 load");
    rev_span = 4'd0; rev_step = 16'h0001;
    step(1'b1, 4'd13, 16'h0, 1'b1, 16'hABCE, "R9 N=1 first");
    step(1'b1, 4'd13, 16'h0, 1'b1, 16'hABCF, "R9 N=1 second");
    step(1'b1, 4'd8,  16'h0, 1'b1, 16'hABCE, "R9 N=1 carry dropped");

    // R10 idle with an increment on the bus
    step(1'b0, 4'd9, 16'h0, 1'b0, 16'h0000, "R10 idle no address");
    step(1'b0, 4'd6, 16'h01FF, 1'b0, 16'h0000, "R10 idle page");
    step(1'b1, 4'd8, 16'h0, 1'b1, 16'hABCE, "R10 AR held");
    step(1'b1, 4'd7, 16'h0001, 1'b1, 16'hD281, "R10 page held");

    // R1 mid-run reset
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'd8, 16'h0, 1'b1, 16'h0000, "R1 reset ptr and AR0");
    step(1'b1, 4'd5, 16'h0003, 1'b0, 16'h0000, "R1 select AR3");
    step(1'b1, 4'd8, 16'h0, 1'b1, 16'h0000, "R1 AR3 cleared");
    step(1'b1, 4'd7, 16'h0011, 1'b1, 16'h0011, "R1 page cleared");

    @(negedge clk);
    cmd_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule